// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. It serialises bytes onto a transmit line and recovers bytes from a receive line. A 6-bit mode word selects four things: whether a parity bit is used and which sense it has, whether one or two stop bits are sent, whether an address/data flag bit takes the place of parity, and how far the system clock is divided before the bit-rate counter. The line idles high. Each frame starts with a low start bit, and data goes out least significant bit first.

The transmit side accepts an 8-bit byte, plus a flag bit that is used only in flag mode, through a valid/ready handshake. The receive side presents each byte for one cycle, together with parity-error, framing-error and received-flag indications. A prescaler and an 8-bit rate value together produce a 16x oversampling tick. Both directions use this tick to time their bits.

Top module: `serial_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A transmitted frame has these bits in order: a 0 start bit, then the 8 data bits with bit 0 first, then an optional extra bit, then the stop bits, which are 1.
- R3: When `mode_cfg[5]` (parity on) is 1 and `mode_cfg[2]` (flag mode) is 0, a parity bit is sent as the extra bit. With `mode_cfg[4]`=0 it makes the count of ones in data plus parity even; with `mode_cfg[4]`=1 it makes the count odd. Without parity or flag mode there is no extra bit.
- R4: `mode_cfg[3]`=0 sends one stop bit and `mode_cfg[3]`=1 sends two. `tx_ready` returns to 1 only after the last stop bit.
- R5: When `mode_cfg[2]`=1, the extra bit carries `tx_flag` and no parity bit is sent, whatever `mode_cfg[5:4]` hold.
- R6: One bit lasts 16*(N+1)*P system clocks, where N is `baud_div` and P is 1, 4, 16 or 64 for `mode_cfg[1:0]` = 00, 01, 10, 11.
- R7: Each received frame gives exactly one single-cycle `rx_valid` pulse, with `rx_data` holding the received byte. This is checked by looping `txd` back to `rxd`.
- R8: With parity on and flag mode off, a received parity bit that does not match the selected sense sets `rx_par_err` with the byte.
- R9: A 0 sampled at the first stop bit sets `rx_frm_err`, and the byte is still delivered.
- R10: The receiver checks only the first stop bit, even when two are configured. A start bit in the second stop position begins a new frame, and both frames are received.
- R11: A low pulse on `rxd` that is high again at the middle of the start bit is discarded without any `rx_valid`. A following valid frame is still received.
- R12: In flag mode the received extra bit appears on `rx_flag`, and `rx_par_err` stays 0.
- R13: While a frame is being sent, `tx_ready` is 0 and `tx_valid` is ignored. Only the byte accepted first goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cfg | input | 6 | [5] parity on, [4] odd parity, [3] two stop bits, [2] flag mode, [1:0] prescale select |
| baud_div | input | 8 | Bit-rate value N; the tick comes every (N+1) prescaled clocks |
| tx_data | input | 8 | Byte to send |
| tx_flag | input | 1 | Extra bit value used in flag mode |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle, accepts a request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse per received frame |
| rx_par_err | output | 1 | Parity mismatch on last byte |
| rx_frm_err | output | 1 | First stop bit was 0 on last byte |
| rx_flag | output | 1 | Extra bit received in flag mode |

## Verification
Frames are sent over loopback under four settings: no extra bit, even parity, odd parity and flag mode. Bit-by-bit capture of `txd` shows whether the extra bit is missing, sits in the wrong place or holds the wrong value. The bit length is measured for four prescale and rate pairs, which shows whether the prescale select or the rate term is wrong. Hand-driven `rxd` waveforms then supply what loopback cannot produce: a bad parity bit, a low stop bit, a start bit right after a single stop bit, and a short glitch. Each of these separates one receive decision from the others.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int OVS    = 16;
    localparam int CNT_W  = $clog2(OVS);
    localparam int MID_TK = OVS / 2 - 1;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_DATA, PH_EXTRA, PH_STOP1, PH_STOP2
    } phase_e;

    typedef struct packed {
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic       mp_en;
        logic [1:0] clk_sel;
    } mode_t;
endpackage

// File: rtl/xcvr_tick_gen.sv
module xcvr_tick_gen #(
    parameter int RATE_W     = 8,
    parameter int PRE_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic [RATE_W-1:0] baud_div,
    output logic              tick
);
    localparam int PRE_W = 2 * PRE_STAGES;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [RATE_W-1:0] rate;
        logic              tick;
    } tg_t;

    tg_t q, d;
    logic [PRE_W-1:0] pre_lim;

    always_comb begin
        pre_lim = PRE_W'((32'd1 << (2 * clk_sel)) - 32'd1);
        d       = q;
        d.tick  = 1'b0;
        if (q.pre >= pre_lim) begin
            d.pre = '0;
            if (q.rate >= baud_div) begin
                d.rate = '0;
                d.tick = 1'b1;
            end else begin
                d.rate = q.rate + 1'b1;
            end
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R6: with any prescale above 1 two ticks are never adjacent
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clk_sel != 2'b00) |=> !tick);
endmodule

// File: rtl/xcvr_tx.sv
module xcvr_tx
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_flag,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd
);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  sh;
        logic               extra;
        logic               has_extra;
        logic               stop2;
        logic               txd;
    } tx_t;

    tx_t q, d;
    logic bit_end;

    always_comb begin
        d       = q;
        bit_end = tick && (q.cnt == CNT_W'(OVS - 1));
        if (q.ph == PH_IDLE) begin
            d.txd = 1'b1;
            if (tx_valid) begin
                d.ph        = PH_START;
                d.cnt       = '0;
                d.idx       = '0;
                d.sh        = tx_data;
                d.has_extra = mp_en | par_en;
                d.extra     = mp_en ? tx_flag : ((^tx_data) ^ par_odd);
                d.stop2     = two_stop;
                d.txd       = 1'b0;
            end
        end else begin
            if (tick) d.cnt = q.cnt + 1'b1;
            if (bit_end) begin
                unique case (q.ph)
                    PH_START: begin
                        d.ph  = PH_DATA;
                        d.txd = q.sh[0];
                    end
                    PH_DATA: begin
                        if (q.idx == IDX_W'(DATA_W - 1)) begin
                            d.ph  = q.has_extra ? PH_EXTRA : PH_STOP1;
                            d.txd = q.has_extra ? q.extra : 1'b1;
                        end else begin
                            d.idx = q.idx + 1'b1;
                            d.sh  = q.sh >> 1;
                            d.txd = q.sh[1];
                        end
                    end
                    PH_EXTRA: begin
                        d.ph  = PH_STOP1;
                        d.txd = 1'b1;
                    end
                    PH_STOP1: d.ph = q.stop2 ? PH_STOP2 : PH_IDLE;
                    default:  d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.ph  <= PH_IDLE;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_ready = (q.ph == PH_IDLE);
    assign txd      = q.txd;

    // R1: an idle transmitter holds the line high
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);
    // R13: an accepted request makes the block busy and starts a low start bit
    a_r13_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && !txd));
endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              mp_en,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_flag
);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic               s1;
        logic               s2;
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  sh;
        logic               extra;
        logic [DATA_W-1:0]  data;
        logic               valid;
        logic               perr;
        logic               ferr;
        logic               flag;
    } rx_t;

    rx_t q, d;
    logic mid, last;

    always_comb begin
        d       = q;
        d.s1    = rxd;
        d.s2    = q.s1;
        d.valid = 1'b0;
        mid     = tick && (q.cnt == CNT_W'(MID_TK));
        last    = tick && (q.cnt == CNT_W'(OVS - 1));
        if (q.ph == PH_IDLE) begin
            if (tick && !q.s2) begin
                d.ph  = PH_START;
                d.cnt = '0;
                d.idx = '0;
            end
        end else begin
            if (tick) d.cnt = q.cnt + 1'b1;
            unique case (q.ph)
                PH_START: begin
                    if (mid && q.s2) d.ph = PH_IDLE;
                    else if (last)   d.ph = PH_DATA;
                end
                PH_DATA: begin
                    if (mid) d.sh = {q.s2, q.sh[DATA_W-1:1]};
                    if (last) begin
                        if (q.idx == IDX_W'(DATA_W - 1))
                            d.ph = (mp_en || par_en) ? PH_EXTRA : PH_STOP1;
                        else
                            d.idx = q.idx + 1'b1;
                    end
                end
                PH_EXTRA: begin
                    if (mid)  d.extra = q.s2;
                    if (last) d.ph = PH_STOP1;
                end
                default: begin
                    if (mid) begin
                        d.ph    = PH_IDLE;
                        d.valid = 1'b1;
                        d.data  = q.sh;
                        d.ferr  = !q.s2;
                        d.perr  = !mp_en && par_en &&
                                  (q.extra != ((^q.sh) ^ par_odd));
                        d.flag  = mp_en && q.extra;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rx_data    = q.data;
    assign rx_valid   = q.valid;
    assign rx_par_err = q.perr;
    assign rx_frm_err = q.ferr;
    assign rx_flag    = q.flag;

    // R7: each frame is reported by a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R12: flag mode never reports a parity error
    a_r12_flag_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(mp_en)) |-> !rx_par_err);
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
    import xcvr_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RATE_W     = 8,
    parameter int PRE_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        mode_cfg,
    input  logic [RATE_W-1:0] baud_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_flag,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_flag
);
    mode_t mode;
    logic  tick;

    assign mode = mode_t'(mode_cfg);

    xcvr_tick_gen #(.RATE_W(RATE_W), .PRE_STAGES(PRE_STAGES)) tick_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(mode.clk_sel),
        .baud_div(baud_div), .tick(tick)
    );

    xcvr_tx #(.DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .par_en(mode.par_en), .par_odd(mode.par_odd),
        .two_stop(mode.two_stop), .mp_en(mode.mp_en),
        .tx_data(tx_data), .tx_flag(tx_flag), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd)
    );

    xcvr_rx #(.DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .par_en(mode.par_en), .par_odd(mode.par_odd), .mp_en(mode.mp_en),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_flag(rx_flag)
    );
endmodule

// File: tb/serial_xcvr_tb.sv
module serial_xcvr_tb_top;
    localparam int CLK_PER = 10;
    localparam int BP      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] mode_cfg = '0;
    logic [7:0] baud_div = '0;
    logic [7:0] tx_data = '0;
    logic       tx_flag = 1'b0;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd, rxd;
    logic [7:0] rx_data;
    logic       rx_valid, rx_par_err, rx_frm_err, rx_flag;
    logic       loop_en = 1'b1;
    logic       rxd_drv = 1'b1;

    int tests = 0;
    int fails = 0;
    int rx_cnt = 0;
    logic [7:0] got_d [4];
    logic       got_p [4];
    logic       got_f [4];
    logic       got_m [4];

    assign rxd = loop_en ? txd : rxd_drv;

    always #(CLK_PER / 2) clk = ~clk;

    serial_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .baud_div(baud_div),
        .tx_data(tx_data), .tx_flag(tx_flag), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_flag(rx_flag)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got_d[rx_cnt % 4] <= rx_data;
            got_p[rx_cnt % 4] <= rx_par_err;
            got_f[rx_cnt % 4] <= rx_frm_err;
            got_m[rx_cnt % 4] <= rx_flag;
            rx_cnt <= rx_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] make_frame(input logic [7:0] d, input bit ext_on,
                                               input logic ext, input int nstop,
                                               output int len);
        logic [15:0] f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[1 + i] = d[i];
        len = 9;
        if (ext_on) begin f[9] = ext; len = 10; end
        len += nstop;
        return f;
    endfunction

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
        while (!tx_ready) @(negedge clk);
        repeat (BP * 2) @(negedge clk);
    endtask

    task automatic send_capture(input logic [7:0] d, input logic f, input int n,
                                output logic [15:0] bits, output logic [15:0] rdy);
        bits = '1; rdy = '0;
        @(negedge clk); tx_data = d; tx_flag = f; tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); tx_valid = 1'b0;
        repeat (BP / 2 - 1) @(negedge clk);
        bits[0] = txd; rdy[0] = tx_ready;
        for (int i = 1; i < n; i++) begin
            repeat (BP) @(negedge clk);
            bits[i] = txd; rdy[i] = tx_ready;
        end
    endtask

    task automatic drive_frame(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rxd_drv = bits[i];
            repeat (BP - 1) @(negedge clk);
        end
        @(negedge clk); rxd_drv = 1'b1;
    endtask

    task automatic t_reset();
        check(txd === 1'b1, "R1 txd idle", txd, 1);
        check(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
        check(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);
    endtask

    task automatic t_frame(input logic [5:0] m, input logic [7:0] d, input logic f,
                           input string req);
        logic [15:0] bits, rdy, exp;
        int len, c0;
        bit ext_on;
        logic ext;
        mode_cfg = m; loop_en = 1'b1; c0 = rx_cnt;
        ext_on = m[2] | m[5];
        ext = m[2] ? f : ((^d) ^ m[4]);
        exp = make_frame(d, ext_on, ext, m[3] ? 2 : 1, len);
        send_capture(d, f, len, bits, rdy);
        for (int i = 0; i < len; i++)
            check(bits[i] === exp[i], req, int'(bits[i]), int'(exp[i]));
        idle_wait(BP);
        check(rx_cnt == c0 + 1, "R7 one rx_valid", rx_cnt - c0, 1);
        check(got_d[c0 % 4] === d, "R7 rx_data loopback", got_d[c0 % 4], d);
        check(got_p[c0 % 4] === 1'b0, "R8 no parity error", got_p[c0 % 4], 0);
        check(got_f[c0 % 4] === 1'b0, "R9 no framing error", got_f[c0 % 4], 0);
        check(got_m[c0 % 4] === (m[2] & f), "R12 rx_flag", got_m[c0 % 4], m[2] & f);
    endtask

    task automatic t_stop_len();
        logic [15:0] bits, rdy;
        mode_cfg = 6'b000000; loop_en = 1'b1;
        send_capture(8'h3C, 1'b0, 11, bits, rdy);
        check(rdy[9] === 1'b0, "R4 busy in stop 1", rdy[9], 0);
        check(rdy[10] === 1'b1, "R4 one stop ready", rdy[10], 1);
        idle_wait(BP);
        mode_cfg = 6'b001000;
        send_capture(8'h3C, 1'b0, 12, bits, rdy);
        check(bits[10] === 1'b1, "R4 second stop high", bits[10], 1);
        check(rdy[10] === 1'b0, "R4 two stop busy", rdy[10], 0);
        check(rdy[11] === 1'b1, "R4 two stop ready", rdy[11], 1);
        idle_wait(BP);
    endtask

    task automatic t_rate(input logic [1:0] sel, input logic [7:0] n, input int exp);
        int len = 0;
        mode_cfg = {4'b0000, sel}; baud_div = n; loop_en = 1'b1;
        @(negedge clk); tx_data = 8'h01; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
        while (txd !== 1'b1) @(negedge clk);
        while (txd === 1'b1) begin len++; @(negedge clk); end
        check(len == exp, "R6 bit length", len, exp);
        while (!tx_ready) @(negedge clk);
        baud_div = '0; mode_cfg = '0;
        idle_wait(BP * 64);
    endtask

    task automatic t_busy();
        int c0 = rx_cnt;
        mode_cfg = '0; loop_en = 1'b1;
        @(negedge clk); tx_data = 8'h12; tx_valid = 1'b1;
        @(negedge clk); tx_data = 8'hFF;
        check(tx_ready === 1'b0, "R13 ready low while busy", tx_ready, 0);
        repeat (40) @(negedge clk);
        check(tx_ready === 1'b0, "R13 still busy", tx_ready, 0);
        tx_valid = 1'b0;
        idle_wait(BP * 12);
        check(rx_cnt == c0 + 1, "R13 single frame", rx_cnt - c0, 1);
        check(got_d[c0 % 4] === 8'h12, "R13 first byte kept", got_d[c0 % 4], 8'h12);
    endtask

    task automatic t_rx_errors();
        logic [15:0] fr;
        int len, c0;
        loop_en = 1'b0;
        mode_cfg = 6'b100000; c0 = rx_cnt;
        fr = make_frame(8'h5A, 1'b1, 1'b1, 1, len);
        drive_frame(fr, len);
        repeat (BP * 2) @(negedge clk);
        check(rx_cnt == c0 + 1, "R8 byte delivered", rx_cnt - c0, 1);
        check(got_p[c0 % 4] === 1'b1, "R8 parity error", got_p[c0 % 4], 1);
        check(got_d[c0 % 4] === 8'h5A, "R8 data", got_d[c0 % 4], 8'h5A);
        mode_cfg = 6'b000000; c0 = rx_cnt;
        fr = make_frame(8'hC3, 1'b0, 1'b0, 1, len);
        fr[9] = 1'b0;
        drive_frame(fr, len);
        repeat (BP * 3) @(negedge clk);
        check(rx_cnt == c0 + 1, "R9 byte delivered", rx_cnt - c0, 1);
        check(got_f[c0 % 4] === 1'b1, "R9 framing error", got_f[c0 % 4], 1);
        check(got_d[c0 % 4] === 8'hC3, "R9 data", got_d[c0 % 4], 8'hC3);
        mode_cfg = 6'b000100; c0 = rx_cnt;
        fr = make_frame(8'h81, 1'b1, 1'b0, 1, len);
        drive_frame(fr, len);
        repeat (BP * 2) @(negedge clk);
        check(got_m[c0 % 4] === 1'b0, "R12 flag zero", got_m[c0 % 4], 0);
        check(got_p[c0 % 4] === 1'b0, "R12 no parity in flag mode", got_p[c0 % 4], 0);
        loop_en = 1'b1;
    endtask

    task automatic t_back_to_back();
        logic [15:0] fa, fb;
        int la, lb, c0;
        loop_en = 1'b0; mode_cfg = 6'b001000; c0 = rx_cnt;
        fa = make_frame(8'h96, 1'b0, 1'b0, 1, la);
        fb = make_frame(8'h2D, 1'b0, 1'b0, 1, lb);
        drive_frame(fa, la);
        drive_frame(fb, lb);
        repeat (BP * 2) @(negedge clk);
        check(rx_cnt == c0 + 2, "R10 two frames", rx_cnt - c0, 2);
        check(got_d[c0 % 4] === 8'h96, "R10 first byte", got_d[c0 % 4], 8'h96);
        check(got_d[(c0 + 1) % 4] === 8'h2D, "R10 second byte", got_d[(c0 + 1) % 4], 8'h2D);
        check(got_f[(c0 + 1) % 4] === 1'b0, "R10 no framing error", got_f[(c0 + 1) % 4], 0);
        loop_en = 1'b1; mode_cfg = '0;
    endtask

    task automatic t_glitch();
        logic [15:0] fr;
        int len, c0;
        loop_en = 1'b0; mode_cfg = '0; c0 = rx_cnt;
        @(negedge clk); rxd_drv = 1'b0;
        repeat (4) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (BP * 12) @(negedge clk);
        check(rx_cnt == c0, "R11 glitch ignored", rx_cnt - c0, 0);
        fr = make_frame(8'h7E, 1'b0, 1'b0, 1, len);
        drive_frame(fr, len);
        repeat (BP * 2) @(negedge clk);
        check(rx_cnt == c0 + 1, "R11 frame after glitch", rx_cnt - c0, 1);
        check(got_d[c0 % 4] === 8'h7E, "R11 data after glitch", got_d[c0 % 4], 8'h7E);
        loop_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_frame(6'b000000, 8'hA5, 1'b0, "R2 plain frame bits");
        t_frame(6'b100000, 8'h07, 1'b0, "R3 even parity frame");
        t_frame(6'b110000, 8'h07, 1'b0, "R3 odd parity frame");
        t_frame(6'b110000, 8'h3C, 1'b0, "R3 odd parity even data");
        t_frame(6'b100100, 8'h33, 1'b1, "R5 flag set frame");
        t_frame(6'b110100, 8'h01, 1'b0, "R5 flag clear frame");
        t_stop_len();
        t_rate(2'b01, 8'd0, 64);
        t_rate(2'b00, 8'd2, 48);
        t_rate(2'b10, 8'd1, 512);
        t_rate(2'b11, 8'd0, 1024);
        t_busy();
        t_rx_errors();
        t_back_to_back();
        t_glitch();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PER * 190000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule